// File: doc/BRIEF.md
# Pipelined Reciprocal-Squared Mantissa Divider

This block divides two floating-point operands whose mantissas already carry the restored hidden one. Both mantissas are unsigned fixed-point values in [1,2) with `FRAC_W` fraction bits. No digit recurrence is used. The divisor is cut into a high slice and a low slice. The high slice addresses a small table holding the reciprocal of its own square. Two multiplies then finish the quotient as X·(Yh − Yl)·(1/Yh²). This first-order expansion works because Y·(Yh − Yl) = Yh² − Yl², and Yl² lies far below the result's resolution.

The pipeline accepts a new operand pair on every clock. A `ready` pulse travels alongside each pair and comes out as `done`, together with its result, a fixed `LATENCY` cycles later. An exception flag supplied with the operands is carried along to the output. The block also XORs the signs and forms a re-biased exponent difference. Its raw quotient keeps one integer bit and leaves normalisation and rounding to a separate downstream stage. A divisor with a clear hidden bit is treated as zero: the block flags it and forces the exponent field to all ones.

Top module: `fpdiv_taylor`

## Requirements
- R1: For nonzero operands, with X = mantA/2^FRAC_W and Y = mantB/2^FRAC_W, the raw quotient qMant/2^(FRAC_W+2) differs from X/Y by less than (1 + X/Y)·2^-(FRAC_W+1). The raw quotient has 1 integer bit and FRAC_W+2 fraction bits.
- R2: qSign equals signA XOR signB.
- R3: qExp is the two's-complement value expA − expB + (2^(EXP_W−1) − 1), held in EXP_W+2 bits, so that results above the exponent range and below zero stay representable.
- R4: Each cycle with `ready` high produces exactly one `done` cycle, exactly LATENCY clock edges later (14 by default). Results come out in issue order, and `done` never rises without an earlier issue.
- R5: Operand pairs issued on consecutive cycles all complete, one result per cycle, with no stall.
- R6: `excIn` sampled with `ready` appears on `excOut` in the same cycle as that pair's `done`. The data result is unaffected. `excOut` is low whenever `done` is low.
- R7: A divisor whose mantissa MSB (hidden bit) is 0 raises `excOut`, sets every bit of qExp to 1 and sets qMant to 0.
- R8: A dividend whose mantissa MSB is 0 (zero), divided by a nonzero divisor, gives qMant = 0 with `excOut` low, unless `excIn` was set.
- R9: While reset is held, `done`, `excOut`, qSign, qExp and qMant are all 0.
- R10: While `done` is low, qSign, qExp and qMant keep the last result. Operand pins driven while `ready` is low have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready | input | 1 | Operand pair valid this cycle |
| excIn | input | 1 | Exception flag travelling with the operands |
| signA | input | 1 | Dividend sign |
| expA | input | EXP_W | Dividend biased exponent |
| mantA | input | FRAC_W+1 | Dividend mantissa, hidden bit at MSB |
| signB | input | 1 | Divisor sign |
| expB | input | EXP_W | Divisor biased exponent |
| mantB | input | FRAC_W+1 | Divisor mantissa, hidden bit at MSB |
| done | output | 1 | Result valid |
| excOut | output | 1 | Carried exception or zero divisor |
| qSign | output | 1 | Quotient sign |
| qExp | output | EXP_W+2 | Re-biased exponent, two's complement |
| qMant | output | FRAC_W+3 | Raw quotient, 1 integer bit |

## Verification
The hardest case to reach is the divisor whose low slice is all ones while its high slice is minimal. There the neglected Yl² term is at its largest. Pairing that divisor with a dividend close to 2 pushes the quotient toward the top of its range, where the error budget is tightest. The stimulus builds this pair directly, alongside random pairs issued back to back. A second hard spot is a zero divisor or a flagged exception sitting among valid neighbours in a full pipeline. Directed sequences interleave such pairs with ordinary ones. A per-cycle monitor then confirms that the flag stays attached to its own result slot.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

  // Strobes handed from the control pipeline to the datapath
  typedef struct packed {
    logic acceptIn;      // stage-1 operand capture
    logic captureOut;    // output register load
    logic forceZeroDiv;  // replace result with zero-divisor pattern
  } divStrobe_t;

  function automatic int unsigned expBias(input int unsigned expWidth);
    return (32'd1 << (expWidth - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/fpdiv_delay.sv
module fpdiv_delay #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);

  generate
    if (N == 0) begin : g_pass
      assign dOut = dIn;
    end else begin : g_regs
      logic [W-1:0] taps [N];
      always_ff @(posedge clk) begin
        taps[0] <= dIn;
        for (int i = 1; i < N; i++) taps[i] <= taps[i-1];
      end
      assign dOut = taps[N-1];
    end
  endgenerate

endmodule

// File: rtl/fpdiv_recip_rom.sv
module fpdiv_recip_rom #(
  parameter int IDX_W = 12,
  parameter int RF    = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] addr,
  output logic [RF:0]      rdData
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int RW    = RF + 1;

  // round(2^RF / Yh^2), Yh = 1 + idx/2^IDX_W
  function automatic logic [RW-1:0] recipSq(input int unsigned idx);
    longint unsigned n;
    longint unsigned nsq;
    longint unsigned num;
    longint unsigned r;
    n   = (64'd1 << IDX_W) + 64'(idx);
    nsq = n * n;
    num = 64'd1 << (RF + 2 * IDX_W);
    r   = (num + (nsq >> 1)) / nsq;
    return r[RW-1:0];
  endfunction

  logic [RW-1:0] romArr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign romArr[g] = recipSq(g);
  end

  always_ff @(posedge clk) rdData <= romArr[addr];

  // value lies in (2^(RF-2), 2^RF]
  AST_TABLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData <= RW'(64'd1 << RF)) && (rdData > RW'(64'd1 << (RF - 2)))); // R1

endmodule

// File: rtl/fpdiv_ctrl.sv
module fpdiv_ctrl
  import fpdiv_pkg::*;
#(
  parameter int LATENCY = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       excIn,
  input  logic       divisorHidden,
  output divStrobe_t strobe,
  output logic       done,
  output logic       excOut
);

  localparam int CW = $clog2(LATENCY + 2);

  logic [LATENCY-1:0] vldPipe;
  logic [LATENCY-1:0] excPipe;
  logic [LATENCY-1:0] zdPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vldPipe <= '0;
      excPipe <= '0;
      zdPipe  <= '0;
    end else begin
      vldPipe <= {vldPipe[LATENCY-2:0], ready};
      excPipe <= {excPipe[LATENCY-2:0], ready & excIn};
      zdPipe  <= {zdPipe[LATENCY-2:0],  ready & ~divisorHidden};
    end
  end

  always_comb begin
    strobe.acceptIn     = ready;
    strobe.captureOut   = vldPipe[LATENCY-2];
    strobe.forceZeroDiv = zdPipe[LATENCY-2];
  end

  assign done   = vldPipe[LATENCY-1];
  assign excOut = excPipe[LATENCY-1] | zdPipe[LATENCY-1];

  // Occupancy tracker used only by the checks below
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(ready) - CW'(done);
  end

  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LATENCY)); // R5
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> inflight != '0); // R4
  AST_DONE_RESET: assert property (@(posedge clk)
    !rst_n |=> (!done && !excOut)); // R9

endmodule

// File: rtl/fpdiv_datapath.sv
module fpdiv_datapath
  import fpdiv_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int IDX_W   = 12,
  parameter int LATENCY = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  divStrobe_t        strobe,
  input  logic              signA,
  input  logic [EXP_W-1:0]  expA,
  input  logic [FRAC_W:0]   mantA,
  input  logic              signB,
  input  logic [EXP_W-1:0]  expB,
  input  logic [FRAC_W:0]   mantB,
  output logic              qSign,
  output logic [EXP_W+1:0]  qExp,
  output logic [FRAC_W+2:0] qMant
);

  localparam int MW     = FRAC_W + 1;       // operand width (2m)
  localparam int LOW_W  = FRAC_W - IDX_W;   // low slice width
  localparam int RF     = FRAC_W + 4;       // table fraction bits
  localparam int RW     = RF + 1;
  localparam int P1F    = FRAC_W + 5;       // kept fraction bits of X*D
  localparam int P1W    = P1F + 2;
  localparam int QW     = FRAC_W + 3;       // raw quotient (2m+2)
  localparam int EW2    = EXP_W + 2;
  localparam int SH1    = 2 * FRAC_W - P1F;
  localparam int SH2    = P1F + RF - (QW - 1);
  localparam int PW2    = P1W + RW;
  localparam int META_W = 1 + EW2;
  localparam int Q_PAD  = LATENCY - 7;      // from stage 6 to stage LATENCY-1
  localparam int M_PAD  = LATENCY - 2;      // from stage 1 to stage LATENCY-1
  localparam int BIAS   = int'(expBias(EXP_W));

  // Stage 1: operand capture, sign and exponent
  logic [MW-1:0]     xS1, yS1;
  logic [META_W-1:0] metaS1;
  always_ff @(posedge clk) begin
    if (strobe.acceptIn) begin
      xS1    <= mantA;
      yS1    <= mantB;
      metaS1 <= {signA ^ signB,
                 EW2'(expA) - EW2'(expB) + EW2'(BIAS)};
    end
  end

  // Stage 2: table read and Yh - Yl
  logic [IDX_W-1:0] tblIdx;
  logic [LOW_W-1:0] yLow;
  logic [MW-1:0]    yHighFull;
  logic [MW-1:0]    xS2, dS2;
  logic [RW-1:0]    recipS2;

  assign tblIdx    = yS1[FRAC_W-1 -: IDX_W];
  assign yLow      = yS1[LOW_W-1:0];
  assign yHighFull = {1'b1, tblIdx, {LOW_W{1'b0}}};

  fpdiv_recip_rom #(.IDX_W(IDX_W), .RF(RF)) uRom (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (tblIdx),
    .rdData(recipS2)
  );

  always_ff @(posedge clk) begin
    xS2 <= xS1;
    dS2 <= yHighFull - MW'(yLow);
  end

  // Stages 3-4: first multiply X*(Yh-Yl), table value follows
  logic [2*MW-1:0] prodS3;
  logic [RW-1:0]   recipS3, recipS4;
  logic [P1W-1:0]  p1S4;
  always_ff @(posedge clk) begin
    prodS3  <= xS2 * dS2;
    recipS3 <= recipS2;
    p1S4    <= prodS3[SH1 +: P1W];
    recipS4 <= recipS3;
  end

  // Stages 5-6: second multiply and truncation to raw width
  logic [PW2-1:0] prodS5;
  logic [QW-1:0]  qS6;
  always_ff @(posedge clk) begin
    prodS5 <= p1S4 * recipS4;
    qS6    <= prodS5[SH2 +: QW];
  end

  // Alignment to the output stage
  logic [QW-1:0]     qLate;
  logic [META_W-1:0] metaLate;

  fpdiv_delay #(.W(QW), .N(Q_PAD)) uQDelay (
    .clk (clk),
    .dIn (qS6),
    .dOut(qLate)
  );

  fpdiv_delay #(.W(META_W), .N(M_PAD)) uMetaDelay (
    .clk (clk),
    .dIn (metaS1),
    .dOut(metaLate)
  );

  // Output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qSign <= 1'b0;
      qExp  <= '0;
      qMant <= '0;
    end else if (strobe.captureOut) begin
      qSign <= metaLate[META_W-1];
      if (strobe.forceZeroDiv) begin
        qExp  <= '1;
        qMant <= '0;
      end else begin
        qExp  <= metaLate[EW2-1:0];
        qMant <= qLate;
      end
    end
  end

endmodule

// File: rtl/fpdiv_taylor.sv
module fpdiv_taylor
  import fpdiv_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int IDX_W   = 12,
  parameter int LATENCY = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              excIn,
  input  logic              signA,
  input  logic [EXP_W-1:0]  expA,
  input  logic [FRAC_W:0]   mantA,
  input  logic              signB,
  input  logic [EXP_W-1:0]  expB,
  input  logic [FRAC_W:0]   mantB,
  output logic              done,
  output logic              excOut,
  output logic              qSign,
  output logic [EXP_W+1:0]  qExp,
  output logic [FRAC_W+2:0] qMant
);

  divStrobe_t strobe;

  fpdiv_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready        (ready),
    .excIn        (excIn),
    .divisorHidden(mantB[FRAC_W]),
    .strobe       (strobe),
    .done         (done),
    .excOut       (excOut)
  );

  fpdiv_datapath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .IDX_W  (IDX_W),
    .LATENCY(LATENCY)
  ) uPath (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .signA (signA),
    .expA  (expA),
    .mantA (mantA),
    .signB (signB),
    .expB  (expB),
    .mantB (mantB),
    .qSign (qSign),
    .qExp  (qExp),
    .qMant (qMant)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(qMant) && $stable(qExp) && $stable(qSign))); // R10
  AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    excOut |-> done); // R6

endmodule

// File: tb/tb_fpdiv_taylor.sv
`timescale 1ns/1ps
module tb_fpdiv_taylor;

  localparam int EXP_W = 8;
  localparam int FRAC_W = 23;
  localparam int LAT = 14;
  localparam int MW = FRAC_W + 1;
  localparam int QW = FRAC_W + 3;

  typedef struct packed {
    int              due;
    logic            sa, sb, exc;
    logic [EXP_W-1:0] ea, eb;
    logic [MW-1:0]   ma, mb;
  } op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready = 1'b0, excIn = 1'b0;
  logic signA = 1'b0, signB = 1'b0;
  logic [EXP_W-1:0] expA = '0, expB = '0;
  logic [MW-1:0] mantA = '0, mantB = '0;
  logic done, excOut, qSign;
  logic [EXP_W+1:0] qExp;
  logic [QW-1:0] qMant;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  op_t pend[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpdiv_taylor dut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .excIn(excIn),
    .signA(signA), .expA(expA), .mantA(mantA),
    .signB(signB), .expB(expB), .mantB(mantB),
    .done(done), .excOut(excOut), .qSign(qSign), .qExp(qExp), .qMant(qMant)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic checkResult(input op_t o);
    real x, y, q, got, err, tol;
    int expE;
    chk(qSign == (o.sa ^ o.sb), "R2", "sign", qSign, o.sa ^ o.sb);
    if (!o.mb[MW-1]) begin
      // R7 zero divisor
      chk(excOut == 1'b1, "R7", "excOut", excOut, 1);
      chk(qExp == '1, "R7", "exp all ones", qExp, 10'h3FF);
      chk(qMant == '0, "R7", "mant zero", qMant, 0);
      return;
    end
    expE = int'(o.ea) - int'(o.eb) + 127;
    chk(int'($signed(qExp)) == expE, "R3", "exponent", int'($signed(qExp)), expE);
    chk(excOut == o.exc, "R6", "excOut", excOut, o.exc);
    if (!o.ma[MW-1]) begin
      chk(qMant == '0, "R8", "zero dividend mant", qMant, 0);
      return;
    end
    x = real'(o.ma) / (2.0 ** FRAC_W);
    y = real'(o.mb) / (2.0 ** FRAC_W);
    q = x / y;
    got = real'(qMant) / (2.0 ** (FRAC_W + 2));
    err = (got > q) ? got - q : q - got;
    tol = (1.0 + q) * (2.0 ** (-(FRAC_W + 1)));
    checks++;
    if (err >= tol) begin
      failures++;
      $display("FAIL R1 quotient actual=%0.12f expected=%0.12f (ma=%h mb=%h)",
               got, q, o.ma, o.mb);
    end
  endtask

  // Monitor: R4 timing/order, result checks
  always @(negedge clk) begin
    op_t o;
    if (running) begin
      if (pend.size() > 0 && pend[0].due == cyc) begin
        o = pend.pop_front();
        chk(done == 1'b1, "R4", "done at due cycle", done, 1);
        if (done) checkResult(o);
      end else begin
        chk(done == 1'b0, "R4", "no unexpected done", done, 0);
        chk(excOut == 1'b0, "R6", "excOut low without done", excOut, 0);
      end
    end
  end

  task automatic issue(input logic sa, input logic [EXP_W-1:0] ea, input logic [MW-1:0] ma,
                       input logic sb, input logic [EXP_W-1:0] eb, input logic [MW-1:0] mb,
                       input logic exc);
    op_t o;
    ready = 1'b1; excIn = exc;
    signA = sa; expA = ea; mantA = ma;
    signB = sb; expB = eb; mantB = mb;
    o.due = cyc + LAT; o.sa = sa; o.sb = sb; o.exc = exc;
    o.ea = ea; o.eb = eb; o.ma = ma; o.mb = mb;
    pend.push_back(o);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    ready = 1'b0; excIn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    ready = 1'b0; excIn = 1'b0;
    while (pend.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [MW-1:0] rndMant();
    return {1'b1, FRAC_W'($urandom)};
  endfunction

  task automatic tReset();
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R9", "done in reset", done, 0);
    chk(excOut == 1'b0, "R9", "excOut in reset", excOut, 0);
    chk(qMant == '0 && qExp == '0 && qSign == 1'b0, "R9", "outputs in reset", qMant, 0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
  endtask

  task automatic tBasic();  // R1 exact unity and simple ratios
    issue(0, 127, 24'h800000, 0, 127, 24'h800000, 0);
    issue(0, 130, 24'hC00000, 0, 128, 24'h800000, 0);
    issue(0, 127, 24'h800000, 0, 127, 24'hC00000, 0);
    issue(0, 127, 24'hFFFFFF, 0, 127, 24'hFFFFFF, 0);
    drain();
  endtask

  task automatic tSigns();  // R2
    for (int s = 0; s < 4; s++) issue(s[0], 100, rndMant(), s[1], 90, rndMant(), 0);
    drain();
  endtask

  task automatic tExponents();  // R3 overflow and negative range
    issue(0, 1, 24'h900000, 0, 254, 24'hA00000, 0);
    issue(0, 254, 24'h900000, 0, 1, 24'hA00000, 0);
    issue(1, 0, 24'h800000, 0, 255, 24'h800000, 0);
    drain();
  endtask

  task automatic tWorstLow();  // R1 largest low slice with minimal high slice
    issue(0, 127, 24'hFFFFFF, 0, 127, 24'h8007FF, 0);
    issue(0, 127, 24'h800000, 0, 127, 24'h8007FF, 0);
    issue(0, 127, 24'hFFFFFF, 0, 127, 24'hFFF7FF, 0);
    issue(0, 127, 24'h800001, 0, 127, 24'hFFFFFF, 0);
    drain();
  endtask

  task automatic tStream();  // R5 back-to-back random, R1 accuracy
    for (int i = 0; i < 300; i++)
      issue($urandom % 2, 8'($urandom), rndMant(), $urandom % 2, 8'($urandom), rndMant(), 0);
    drain();
  endtask

  task automatic tGaps();  // R4 spaced issues
    for (int i = 0; i < 10; i++) begin
      issue(0, 120, rndMant(), 1, 110, rndMant(), 0);
      idle(i % 4);
    end
    drain();
  endtask

  task automatic tExcPass();  // R6 flag rides with its slot
    issue(0, 127, rndMant(), 0, 127, rndMant(), 0);
    issue(0, 127, 24'hC00000, 0, 127, 24'h800000, 1);
    issue(0, 127, rndMant(), 0, 127, rndMant(), 0);
    issue(1, 127, rndMant(), 0, 127, rndMant(), 1);
    drain();
  endtask

  task automatic tZeroDiv();  // R7 between valid neighbours
    issue(0, 127, rndMant(), 0, 127, rndMant(), 0);
    issue(1, 127, 24'hA00000, 0, 0, 24'h000000, 0);
    issue(0, 127, rndMant(), 0, 127, rndMant(), 0);
    issue(0, 127, 24'hFFFFFF, 1, 3, 24'h7FFFFF, 0);
    drain();
  endtask

  task automatic tZeroDividend();  // R8
    issue(0, 0, 24'h000000, 0, 127, 24'h9ABCDE, 0);
    issue(1, 0, 24'h000000, 0, 127, 24'hFFFFFF, 0);
    drain();
  endtask

  task automatic tHold();  // R10 outputs hold while ready low
    logic [QW-1:0] keepM;
    logic [EXP_W+1:0] keepE;
    logic keepS;
    issue(1, 140, 24'hB00000, 0, 120, 24'h900000, 0);
    drain();
    keepM = qMant; keepE = qExp; keepS = qSign;
    ready = 1'b0;
    for (int i = 0; i < 20; i++) begin
      signA = ~signA; expA = 8'($urandom); mantA = 24'($urandom);
      mantB = 24'($urandom); expB = 8'($urandom);
      @(negedge clk);
    end
    chk(qMant == keepM, "R10", "mant held", qMant, keepM);
    chk(qExp == keepE, "R10", "exp held", qExp, keepE);
    chk(qSign == keepS, "R10", "sign held", qSign, keepS);
  endtask

  initial begin
    tReset();
    tBasic();
    tSigns();
    tExponents();
    tWorstLow();
    tStream();
    tGaps();
    tExcPass();
    tZeroDiv();
    tZeroDividend();
    tHold();
    running = 1'b0;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule